// File: doc/BRIEF.md
# Data Load Path Sequencer

This block steps one load (byte, halfword or word) through the data side of a memory management unit. It takes a virtual address with its size and four configuration bits. It checks alignment, requests a translation, and probes three external lookup units in a fixed order: the read buffer, the main data cache and then the mini data cache. On a miss it decides between a soft cache flush, a write buffer drain, a line allocation and a plain uncached memory read. The result is returned as a single response that carries either extracted data or a fault code.

Every external unit is reached through the same handshake. The sequencer holds that unit's request line high for as long as its state lasts. The unit answers with a one-cycle done pulse, and its result inputs are sampled in that cycle. At most one request line is high at any time. A request is accepted only in the idle state, and a request presented while a load is in flight is ignored.

The state machine has ten states. ST_IDLE waits and accepts. ST_XLATE waits for the walker. ST_RBUF, ST_MAIN and ST_MINI probe the read buffer, the main cache and the mini cache. ST_FLUSH issues the soft flush. ST_DRAIN empties the write buffer. ST_ALLOC fills a cache line. ST_MEMRD performs the memory read. ST_RESP emits the response for one cycle and then returns to ST_IDLE.

The transitions are as follows:
- ST_IDLE goes to ST_MEMRD when the MMU is off, to ST_RESP on an alignment fault, and to ST_XLATE otherwise.
- ST_XLATE goes to ST_RESP on a walker fault and to ST_RBUF otherwise.
- ST_RBUF goes to ST_RESP on a hit and to ST_MAIN on a miss.
- ST_MAIN goes to ST_RESP on a hit and to ST_MINI on a miss.
- ST_MINI goes to ST_RESP on a hit. On a miss it goes to ST_FLUSH or ST_RESP inside the flush window, and to ST_DRAIN, ST_ALLOC or ST_MEMRD outside it.
- ST_DRAIN goes to ST_ALLOC or ST_MEMRD.
- ST_FLUSH, ST_ALLOC and ST_MEMRD all go to ST_RESP.

Top module: `rdpath_seq`

## Requirements
- R1: With cfg_mmu_on low, only the memory port is used. Its address is the unmodified virtual address and its size is the request size, where size code 0 is a byte, 1 is a halfword and 2 is a word. No alignment check is made.
- R2: With cfg_mmu_on and cfg_align_chk high, a misaligned load touches no unit and responds with fault code 1. A word load is misaligned when VA[1:0] is not 0, and a halfword load is misaligned when VA[0] is 1.
- R3: A nonzero walker fault code is returned unchanged as rsp_fault, with no other unit touched. A zero code means no fault.
- R4: The read buffer is probed first, then the main cache, then the mini cache. The data word of the first unit that hits is used. A read buffer hit with a nonzero stored fault returns that fault.
- R5: If all lookups miss and the physical address lies in [0xE0000000, 0xE8000000), the load returns data 0 with fault 0. It touches neither the write buffer nor memory. When the cacheable flag is set it issues a soft flush, aimed at the main cache if the bufferable flag is set and at the mini cache otherwise.
- R6: Outside the flush window, a miss with the bufferable flag set completes a write buffer drain before any allocation or memory read is started.
- R7: Outside the flush window, a miss that is cacheable while cfg_dcache_on is high allocates a line. It uses the main cache when bufferable and the mini cache otherwise, and returns the allocated data word.
- R8: Any other miss reads memory at {PA[31:2], low bits}. The low bits are VA[1:0] for a byte, {VA[1],0} for a halfword and 00 for a word, and the size is the request size.
- R9: The result is taken from the returned 32-bit word. A halfword is the word shifted right by 8·((2·bigend) XOR (2·VA[1])) and masked to 16 bits. A byte uses a shift of 8·((3·bigend) XOR VA[1:0]) and is masked to 8 bits. A word passes whole.
- R10: Each accepted load produces exactly one rsp_valid pulse. req_valid seen while a load is in flight starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request, sampled in idle |
| req_va | input | 32 | Virtual address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cfg_mmu_on | input | 1 | Translation enabled |
| cfg_align_chk | input | 1 | Alignment checking enabled |
| cfg_dcache_on | input | 1 | Data cache enabled |
| cfg_bigend | input | 1 | Big-endian lane order |
| xl_req | output | 1 | Translation request |
| xl_done | input | 1 | Translation result valid |
| xl_fault | input | 4 | Walker/permission fault, 0 = none |
| xl_pa | input | 32 | Physical address |
| xl_cacheable | input | 1 | Page cacheable flag |
| xl_bufferable | input | 1 | Page bufferable flag |
| lk_va | output | 32 | Word-aligned VA for lookups |
| rb_req | output | 1 | Read buffer probe |
| rb_done | input | 1 | Read buffer answer valid |
| rb_hit | input | 1 | Read buffer hit |
| rb_fault | input | 4 | Stored fault of the hit entry |
| rb_data | input | 32 | Read buffer word |
| mc_req | output | 1 | Main cache probe |
| mc_done | input | 1 | Main cache answer valid |
| mc_hit | input | 1 | Main cache hit |
| mc_data | input | 32 | Main cache word |
| nc_req | output | 1 | Mini cache probe |
| nc_done | input | 1 | Mini cache answer valid |
| nc_hit | input | 1 | Mini cache hit |
| nc_data | input | 32 | Mini cache word |
| phys_addr | output | 32 | Word-aligned physical address |
| sf_req | output | 1 | Soft flush request |
| sf_to_main | output | 1 | Flush target: 1 main, 0 mini |
| sf_done | input | 1 | Flush complete |
| wb_req | output | 1 | Write buffer drain request |
| wb_done | input | 1 | Drain complete |
| al_req | output | 1 | Line allocation request |
| al_to_main | output | 1 | Allocation target: 1 main, 0 mini |
| al_done | input | 1 | Allocation complete |
| al_data | input | 32 | Word from allocated line |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_size | output | 2 | Memory read size |
| mem_done | input | 1 | Memory data valid |
| mem_data | input | 32 | Memory word |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Extracted load data |
| rsp_fault | output | 4 | Fault code, 0 = none |

## Verification
Loads are drawn at random, each with its own mix of MMU, alignment, cache-enable and endianness settings. Each external unit answers with its own hit and fault pattern and after a random latency. The bench checks the returned data and fault. It also checks the set of units that were touched, which separates a wrong probe order, a missing drain and a wrong cache choice from each other even when the data happens to agree. Directed loads cover the edges: both ends of the flush window, odd halfword and word addresses with the check on and off, and each byte lane in both endian orders. Repeated request pulses during long loads show whether a busy sequencer starts a second load.

// File: rtl/rdpath_pkg.sv
package rdpath_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam logic [3:0] FLT_NONE  = 4'h0;
    localparam logic [3:0] FLT_ALIGN = 4'h1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_XLATE,
        ST_RBUF,
        ST_MAIN,
        ST_MINI,
        ST_FLUSH,
        ST_DRAIN,
        ST_ALLOC,
        ST_MEMRD,
        ST_RESP
    } seq_state_e;

endpackage

// File: rtl/rdpath_align.sv
module rdpath_align
    import rdpath_pkg::*;
(
    input  logic [1:0] va_lo,
    input  logic [1:0] size,
    output logic       misaligned
);
    always_comb begin
        unique case (size)
            SZ_HALF: misaligned = va_lo[0];
            SZ_WORD: misaligned = |va_lo;
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/rdpath_win.sv
module rdpath_win #(
    parameter int          AW     = 32,
    parameter logic [AW-1:0] WIN_LO = 32'hE000_0000,
    parameter logic [AW-1:0] WIN_HI = 32'hE800_0000
) (
    input  logic [AW-1:0] pa,
    output logic          in_win
);
    assign in_win = (pa >= WIN_LO) && (pa < WIN_HI);
endmodule

// File: rtl/rdpath_lane.sv
module rdpath_lane
    import rdpath_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] word,
    input  logic [1:0]    size,
    input  logic [1:0]    va_lo,
    input  logic          bigend,
    output logic [DW-1:0] data
);
    localparam int HW = DW / 2;

    logic [1:0] half_sel;
    logic [1:0] byte_sel;
    logic [DW-1:0] half_shift;
    logic [DW-1:0] byte_shift;

    assign half_sel   = {bigend, 1'b0} ^ {va_lo[1], 1'b0};
    assign byte_sel   = {bigend, bigend} ^ va_lo;
    assign half_shift = word >> (8 * half_sel);
    assign byte_shift = word >> (8 * byte_sel);

    always_comb begin
        unique case (size)
            SZ_HALF: data = {{HW{1'b0}}, half_shift[HW-1:0]};
            SZ_BYTE: data = {{(DW-8){1'b0}}, byte_shift[7:0]};
            default: data = word;
        endcase
    end
endmodule

// File: rtl/rdpath_seq.sv
module rdpath_seq
    import rdpath_pkg::*;
#(
    parameter int            AW     = 32,
    parameter int            DW     = 32,
    parameter int            FW     = 4,
    parameter logic [AW-1:0] WIN_LO = 32'hE000_0000,
    parameter logic [AW-1:0] WIN_HI = 32'hE800_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_va,
    input  logic [1:0]    req_size,
    input  logic          cfg_mmu_on,
    input  logic          cfg_align_chk,
    input  logic          cfg_dcache_on,
    input  logic          cfg_bigend,
    output logic          xl_req,
    input  logic          xl_done,
    input  logic [FW-1:0] xl_fault,
    input  logic [AW-1:0] xl_pa,
    input  logic          xl_cacheable,
    input  logic          xl_bufferable,
    output logic [AW-1:0] lk_va,
    output logic          rb_req,
    input  logic          rb_done,
    input  logic          rb_hit,
    input  logic [FW-1:0] rb_fault,
    input  logic [DW-1:0] rb_data,
    output logic          mc_req,
    input  logic          mc_done,
    input  logic          mc_hit,
    input  logic [DW-1:0] mc_data,
    output logic          nc_req,
    input  logic          nc_done,
    input  logic          nc_hit,
    input  logic [DW-1:0] nc_data,
    output logic [AW-1:0] phys_addr,
    output logic          sf_req,
    output logic          sf_to_main,
    input  logic          sf_done,
    output logic          wb_req,
    input  logic          wb_done,
    output logic          al_req,
    output logic          al_to_main,
    input  logic          al_done,
    input  logic [DW-1:0] al_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    input  logic          mem_done,
    input  logic [DW-1:0] mem_data,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [FW-1:0] rsp_fault
);
    localparam int LSB_W = $clog2(DW / 8);

    seq_state_e state, state_nx;

    logic [AW-1:0] va_q;
    logic [1:0]    size_q;
    logic          be_q;
    logic          dce_q;
    logic          bypass_q;
    logic [AW-1:0] pa_q;
    logic          c_q;
    logic          b_q;
    logic [DW-1:0] word_q;
    logic [FW-1:0] fault_q;

    logic          mis_now;
    logic          win_hit;
    logic          fill_ok;
    logic [1:0]    low_bits;
    logic [DW-1:0] lane_out;

    rdpath_align u_align (
        .va_lo      (req_va[1:0]),
        .size       (req_size),
        .misaligned (mis_now)
    );

    rdpath_win #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
        .pa     (pa_q),
        .in_win (win_hit)
    );

    rdpath_lane #(.DW(DW)) u_lane (
        .word   (word_q),
        .size   (size_q),
        .va_lo  (va_q[1:0]),
        .bigend (be_q),
        .data   (lane_out)
    );

    assign fill_ok = c_q && dce_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                if (!cfg_mmu_on)                   state_nx = ST_MEMRD;
                else if (cfg_align_chk && mis_now) state_nx = ST_RESP;
                else                               state_nx = ST_XLATE;
            end
            ST_XLATE: if (xl_done)
                state_nx = (xl_fault != '0) ? ST_RESP : ST_RBUF;
            ST_RBUF: if (rb_done)
                state_nx = rb_hit ? ST_RESP : ST_MAIN;
            ST_MAIN: if (mc_done)
                state_nx = mc_hit ? ST_RESP : ST_MINI;
            ST_MINI: if (nc_done) begin
                if (nc_hit)       state_nx = ST_RESP;
                else if (win_hit) state_nx = c_q ? ST_FLUSH : ST_RESP;
                else if (b_q)     state_nx = ST_DRAIN;
                else if (fill_ok) state_nx = ST_ALLOC;
                else              state_nx = ST_MEMRD;
            end
            ST_DRAIN: if (wb_done)
                state_nx = fill_ok ? ST_ALLOC : ST_MEMRD;
            ST_FLUSH: if (sf_done)  state_nx = ST_RESP;
            ST_ALLOC: if (al_done)  state_nx = ST_RESP;
            ST_MEMRD: if (mem_done) state_nx = ST_RESP;
            ST_RESP:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // captured request and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q     <= '0;
            size_q   <= SZ_WORD;
            be_q     <= 1'b0;
            dce_q    <= 1'b0;
            bypass_q <= 1'b0;
            pa_q     <= '0;
            c_q      <= 1'b0;
            b_q      <= 1'b0;
            word_q   <= '0;
            fault_q  <= FLT_NONE;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q     <= req_va;
                    size_q   <= req_size;
                    be_q     <= cfg_bigend;
                    dce_q    <= cfg_dcache_on;
                    bypass_q <= !cfg_mmu_on;
                    pa_q     <= '0;
                    c_q      <= 1'b0;
                    b_q      <= 1'b0;
                    word_q   <= '0;
                    fault_q  <= (cfg_mmu_on && cfg_align_chk && mis_now) ? FLT_ALIGN : FLT_NONE;
                end
                ST_XLATE: if (xl_done) begin
                    pa_q    <= {xl_pa[AW-1:LSB_W], {LSB_W{1'b0}}};
                    c_q     <= xl_cacheable;
                    b_q     <= xl_bufferable;
                    fault_q <= xl_fault;
                end
                ST_RBUF: if (rb_done && rb_hit) begin
                    fault_q <= rb_fault;
                    word_q  <= (rb_fault != '0) ? '0 : rb_data;
                end
                ST_MAIN:  if (mc_done && mc_hit) word_q <= mc_data;
                ST_MINI:  if (nc_done && nc_hit) word_q <= nc_data;
                ST_ALLOC: if (al_done)           word_q <= al_data;
                ST_MEMRD: if (mem_done)          word_q <= mem_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (size_q)
            SZ_BYTE: low_bits = va_q[1:0];
            SZ_HALF: low_bits = {va_q[1], 1'b0};
            default: low_bits = 2'b00;
        endcase
    end

    // outputs
    always_comb begin
        xl_req     = (state == ST_XLATE);
        rb_req     = (state == ST_RBUF);
        mc_req     = (state == ST_MAIN);
        nc_req     = (state == ST_MINI);
        sf_req     = (state == ST_FLUSH);
        wb_req     = (state == ST_DRAIN);
        al_req     = (state == ST_ALLOC);
        mem_req    = (state == ST_MEMRD);
        lk_va      = {va_q[AW-1:LSB_W], {LSB_W{1'b0}}};
        phys_addr  = pa_q;
        sf_to_main = b_q;
        al_to_main = b_q;
        mem_addr   = bypass_q ? va_q : {pa_q[AW-1:2], low_bits};
        mem_size   = size_q;
        rsp_valid  = (state == ST_RESP);
        rsp_data   = (fault_q != '0) ? '0 : lane_out;
        rsp_fault  = fault_q;
    end

    // assertions
    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_one_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xl_req, rb_req, mc_req, nc_req, sf_req, wb_req, al_req, mem_req}));

    p_align_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && cfg_mmu_on && cfg_align_chk && mis_now)
        |=> (rsp_valid && rsp_fault == FLT_ALIGN));

    p_walk_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && xl_done && xl_fault != '0) |=> (rsp_valid && rsp_fault == $past(xl_fault)));

    p_drain_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_done) |=> (al_req || mem_req));

    p_flush_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sf_req |-> win_hit);

    p_fill_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (al_req || wb_req) |-> !win_hit);

endmodule

// File: tb/rdpath_seq_tb_top.sv
module rdpath_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_size = 2'd2;
    logic        cfg_mmu_on = 1'b0, cfg_align_chk = 1'b0, cfg_dcache_on = 1'b0, cfg_bigend = 1'b0;
    logic [3:0]  xl_fault = '0, rb_fault = '0;
    logic [31:0] xl_pa = '0, rb_data = '0, mc_data = '0, nc_data = '0, al_data = '0, mem_data = '0;
    logic        xl_c = 1'b0, xl_b = 1'b0, rb_hit = 1'b0, mc_hit = 1'b0, nc_hit = 1'b0;
    logic [7:0]  done = '0;

    logic        xl_req, rb_req, mc_req, nc_req, sf_req, wb_req, al_req, mem_req;
    logic        sf_to_main, al_to_main, rsp_valid;
    logic [31:0] lk_va, phys_addr, mem_addr, rsp_data;
    logic [1:0]  mem_size;
    logic [3:0]  rsp_fault;
    logic [7:0]  reqv;

    rdpath_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_size(req_size),
        .cfg_mmu_on(cfg_mmu_on), .cfg_align_chk(cfg_align_chk), .cfg_dcache_on(cfg_dcache_on),
        .cfg_bigend(cfg_bigend),
        .xl_req(xl_req), .xl_done(done[0]), .xl_fault(xl_fault), .xl_pa(xl_pa),
        .xl_cacheable(xl_c), .xl_bufferable(xl_b), .lk_va(lk_va),
        .rb_req(rb_req), .rb_done(done[1]), .rb_hit(rb_hit), .rb_fault(rb_fault), .rb_data(rb_data),
        .mc_req(mc_req), .mc_done(done[2]), .mc_hit(mc_hit), .mc_data(mc_data),
        .nc_req(nc_req), .nc_done(done[3]), .nc_hit(nc_hit), .nc_data(nc_data),
        .phys_addr(phys_addr), .sf_req(sf_req), .sf_to_main(sf_to_main), .sf_done(done[4]),
        .wb_req(wb_req), .wb_done(done[5]),
        .al_req(al_req), .al_to_main(al_to_main), .al_done(done[6]), .al_data(al_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size), .mem_done(done[7]),
        .mem_data(mem_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault)
    );

    assign reqv = {mem_req, al_req, wb_req, sf_req, nc_req, mc_req, rb_req, xl_req};

    int n_chk = 0;
    int n_bad = 0;

    // unit responders and monitor (falling edge)
    int          lat [8];
    logic [7:0]  seen = '0;
    int          rsp_cnt = 0;
    logic [31:0] got_data = '0, got_maddr = '0;
    logic [3:0]  got_fault = '0;
    logic [1:0]  got_msize = '0;
    logic        got_sfm = 1'b0, got_alm = 1'b0;

    always @(negedge clk) begin
        for (int i = 0; i < 8; i++) begin
            if (done[i]) done[i] = 1'b0;
            else if (reqv[i]) begin
                if (lat[i] <= 0) begin
                    done[i] = 1'b1;
                    lat[i]  = $urandom_range(0, 3);
                end else lat[i] = lat[i] - 1;
            end
        end
        seen = seen | reqv;
        if (mem_req) begin got_maddr = mem_addr; got_msize = mem_size; end
        if (sf_req) got_sfm = sf_to_main;
        if (al_req) got_alm = al_to_main;
        if (rsp_valid) begin
            rsp_cnt   = rsp_cnt + 1;
            got_data  = rsp_data;
            got_fault = rsp_fault;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane(input logic [31:0] w, input logic [1:0] sz,
                                         input logic [1:0] lo, input logic be);
        int sh;
        if (sz == 2'd1) begin
            sh = 8 * ((be ? 2 : 0) ^ (lo[1] ? 2 : 0));
            return (w >> sh) & 32'hFFFF;
        end else if (sz == 2'd0) begin
            sh = 8 * ((be ? 3 : 0) ^ int'(lo));
            return (w >> sh) & 32'hFF;
        end
        return w;
    endfunction

    // run one load with the current scenario and compare
    task automatic run_load(input bit poke);
        logic [7:0]  e_mask;
        logic [31:0] e_word, e_data, e_maddr;
        logic [3:0]  e_fault;
        logic        e_win, mis, e_main, path_align;
        int          wait_cyc;

        mis = (req_size == 2'd2) ? (req_va[1:0] != 0) : (req_size == 2'd1) ? req_va[0] : 1'b0;
        e_win = (xl_pa >= 32'hE000_0000) && (xl_pa < 32'hE800_0000);
        e_main = xl_b;
        e_mask = '0; e_word = '0; e_fault = '0; e_maddr = '0;
        path_align = 1'b0;
        if (!cfg_mmu_on) begin
            e_mask = 8'h80; e_word = mem_data; e_maddr = req_va;            // R1
        end else if (cfg_align_chk && mis) begin
            e_fault = 4'h1; path_align = 1'b1;                              // R2
        end else begin
            e_mask = 8'h01;
            if (xl_fault != 0) e_fault = xl_fault;                          // R3
            else begin
                e_mask |= 8'h02;                                            // R4
                if (rb_hit) begin
                    if (rb_fault != 0) e_fault = rb_fault; else e_word = rb_data;
                end else begin
                    e_mask |= 8'h04;
                    if (mc_hit) e_word = mc_data;
                    else begin
                        e_mask |= 8'h08;
                        if (nc_hit) e_word = nc_data;
                        else if (e_win) begin
                            if (xl_c) e_mask |= 8'h10;                      // R5
                        end else begin
                            if (xl_b) e_mask |= 8'h20;                      // R6
                            if (xl_c && cfg_dcache_on) begin
                                e_mask |= 8'h40; e_word = al_data;          // R7
                            end else begin
                                e_mask |= 8'h80;                            // R8
                                e_word = mem_data;
                                e_maddr = {xl_pa[31:2],
                                    (req_size == 2'd0) ? req_va[1:0] :
                                    (req_size == 2'd1) ? {req_va[1], 1'b0} : 2'b00};
                            end
                        end
                    end
                end
            end
        end
        e_data = (e_fault != 0) ? 32'h0 : lane(e_word, req_size, req_va[1:0], cfg_bigend);

        @(negedge clk);
        seen = '0; rsp_cnt = 0; got_sfm = 1'bx; got_alm = 1'bx;
        req_valid = 1'b1;
        @(negedge clk);
        if (poke && !path_align) begin
            @(negedge clk);
            req_valid = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_cyc = 0;
        while (rsp_cnt == 0 && wait_cyc < 100) begin @(negedge clk); wait_cyc++; end
        repeat (4) @(negedge clk);

        check("R10 response count", rsp_cnt, 1);
        check("R9 data", got_data, e_data);
        check("R3 fault", {28'h0, got_fault}, {28'h0, e_fault});
        check("R4 units touched", {24'h0, seen}, {24'h0, e_mask});
        if (e_mask[7]) begin
            check("R8 mem addr", got_maddr, e_maddr);
            check("R1 mem size", {30'h0, got_msize}, {30'h0, req_size});
        end
        if (e_mask[4]) check("R5 flush target", {31'h0, got_sfm}, {31'h0, e_main});
        if (e_mask[6]) check("R7 alloc target", {31'h0, got_alm}, {31'h0, e_main});
    endtask

    task automatic rand_scn();
        req_va        = $urandom;
        req_size      = 2'($urandom_range(0, 2));
        cfg_mmu_on    = ($urandom_range(0, 5) != 0);
        cfg_align_chk = $urandom_range(0, 1);
        cfg_dcache_on = $urandom_range(0, 1);
        cfg_bigend    = $urandom_range(0, 1);
        xl_fault      = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(2, 15)) : 4'h0;
        xl_pa         = ($urandom_range(0, 3) == 0) ? {5'b11100, 27'($urandom)} : $urandom;
        xl_c          = $urandom_range(0, 1);
        xl_b          = $urandom_range(0, 1);
        rb_hit        = ($urandom_range(0, 4) == 0);
        rb_fault      = ($urandom_range(0, 1) == 0) ? 4'($urandom_range(2, 15)) : 4'h0;
        mc_hit        = ($urandom_range(0, 4) == 0);
        nc_hit        = ($urandom_range(0, 4) == 0);
        rb_data = $urandom; mc_data = $urandom; nc_data = $urandom;
        al_data = $urandom; mem_data = $urandom;
    endtask

    task automatic miss_all();
        cfg_mmu_on = 1; xl_fault = 0; rb_hit = 0; mc_hit = 0; nc_hit = 0;
    endtask

    int cyc = 0;
    bit wd_hit = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !wd_hit) begin
            wd_hit = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) lat[i] = 0;
        repeat (3) @(negedge clk);
        check("R10 reset idle", {31'h0, rsp_valid}, 32'h0);
        check("R4 reset no unit", {24'h0, reqv}, 32'h0);
        rst_n = 1'b1;

        // R1: bypass with misaligned word, check ignored
        rand_scn(); cfg_mmu_on = 0; cfg_align_chk = 1; req_size = 2'd2; req_va = 32'h1000_0003;
        run_load(0);
        // R2: word and halfword misaligned
        rand_scn(); cfg_mmu_on = 1; cfg_align_chk = 1; req_size = 2'd2; req_va = 32'h0000_0102;
        run_load(0);
        rand_scn(); cfg_mmu_on = 1; cfg_align_chk = 1; req_size = 2'd1; req_va = 32'h0000_0101;
        run_load(0);
        // R3: walker fault
        rand_scn(); cfg_mmu_on = 1; cfg_align_chk = 0; xl_fault = 4'h5; run_load(1);
        // R4: read buffer stored fault, then hit data, main, mini
        rand_scn(); miss_all(); rb_hit = 1; rb_fault = 4'h9; run_load(0);
        rand_scn(); miss_all(); rb_hit = 1; rb_fault = 0; mc_hit = 1; run_load(0);
        rand_scn(); miss_all(); mc_hit = 1; nc_hit = 1; run_load(0);
        rand_scn(); miss_all(); nc_hit = 1; run_load(0);
        // R5: window edges
        rand_scn(); miss_all(); xl_pa = 32'hE000_0000; xl_c = 1; xl_b = 1; run_load(0);
        rand_scn(); miss_all(); xl_pa = 32'hE7FF_FFFC; xl_c = 1; xl_b = 0; run_load(0);
        rand_scn(); miss_all(); xl_pa = 32'hE000_0000; xl_c = 0; xl_b = 1; run_load(0);
        rand_scn(); miss_all(); xl_pa = 32'hE800_0000; xl_c = 0; xl_b = 0; run_load(0);
        rand_scn(); miss_all(); xl_pa = 32'hDFFF_FFFC; xl_c = 0; xl_b = 0; run_load(0);
        // R6/R7: drain then main alloc; mini alloc
        rand_scn(); miss_all(); xl_pa = 32'h1000_0000; xl_c = 1; xl_b = 1; cfg_dcache_on = 1; run_load(1);
        rand_scn(); miss_all(); xl_pa = 32'h1000_0000; xl_c = 1; xl_b = 0; cfg_dcache_on = 1; run_load(0);
        // R8: cache off, uncached halfword
        rand_scn(); miss_all(); xl_pa = 32'h2000_0040; xl_c = 1; xl_b = 1; cfg_dcache_on = 0;
        req_size = 2'd1; req_va = 32'h0000_0006; cfg_align_chk = 1; run_load(0);
        // R9: each byte lane in both orders
        for (int be = 0; be < 2; be++)
            for (int k = 0; k < 4; k++) begin
                rand_scn(); cfg_mmu_on = 0; cfg_bigend = be[0]; req_size = 2'd0;
                req_va = 32'h0000_0010 | 32'(k); mem_data = 32'hA1B2C3D4; run_load(0);
            end

        // random mix
        for (int n = 0; n < 600; n++) begin
            rand_scn();
            run_load($urandom_range(0, 1));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule